// File: doc/BRIEF.md
# Debug Communications Channel Mailbox

A two-way, single-word mailbox that lets an external debugger and software running on the target exchange 32-bit words. The debugger side behaves as a small register bank driven by the strobes that a debug scan chain produces. A comms control register at address 4 reports the handshake flags and a module version. A comms data register at address 5 carries the words in both directions.

The target side has two streams. A word the target pushes on the inbound stream sets the W flag, which tells the debugger a word is waiting. A word the debugger writes sets the R flag and appears on the outbound stream until the target takes it. The debugger polls W until it reads 1 before reading data. It polls R until it reads 0 before writing again, or it streams words without polling when the target is known to drain each one in time. Reading the data register consumes the word. Reading the control register has no side effect.

The inbound stream never applies back-pressure: `tgt_in_ready` is always high. A push into an occupied mailbox replaces the stored word and raises a sticky overrun bit. The outbound stream holds `tgt_out_valid` and `tgt_out_data` steady until a cycle with `tgt_out_ready` high. The word is consumed in that cycle.

Top module: `dcc_mailbox`

## Requirements
- R1: After reset, R, W and overrun are 0, `tgt_out_valid` is 0 and `dbg_rdata` is 0.
- R2: A debugger read at address 4 returns, in the cycle after the strobe, the control word sampled at the strobe. Bit 0 is R, bit 1 is W, bit 2 is overrun, bits 27:3 are zero and bits 31:28 hold the VERSION parameter. `dbg_rdata` holds its value when there is no read.
- R3: A control read changes none of R, W, overrun or the stored words.
- R4: A cycle with `tgt_in_valid` high stores `tgt_in_data` and sets W for the next cycle. `tgt_in_ready` is always 1.
- R5: A debugger read at address 5 returns the inbound word in the next cycle and clears W. If the target pushes in the same cycle, the new word is stored and W stays 1.
- R6: A debugger write at address 5 stores `dbg_wdata` and sets R. `tgt_out_valid` equals R, and `tgt_out_data` holds the stored word.
- R7: A cycle with `tgt_out_valid` and `tgt_out_ready` both high clears R, unless the debugger writes data in the same cycle.
- R8: A write into a full mailbox in either direction replaces the word and sets the sticky overrun bit. A write in the same cycle as that mailbox is drained is not an overrun.
- R9: A debugger write at address 4 with bit 2 set clears overrun, and its other bits are ignored. If an overrun occurs in the same cycle, overrun stays set.
- R10: A read at any address other than 4 or 5 returns 0. A write at such an address has no effect.
- R11: Back-to-back debugger data writes, one per cycle, are each delivered in order when the target asserts `tgt_out_ready` every cycle, and they raise no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_addr | input | ADDR_W | Debugger register address |
| dbg_wr_en | input | 1 | Debugger write strobe |
| dbg_rd_en | input | 1 | Debugger read strobe |
| dbg_wdata | input | DATA_W | Debugger write data |
| dbg_rdata | output | DATA_W | Debugger read data, valid the cycle after the strobe |
| tgt_in_valid | input | 1 | Target pushes a word to the debugger |
| tgt_in_ready | output | 1 | Always 1; the inbound mailbox accepts every push |
| tgt_in_data | input | DATA_W | Word pushed by the target |
| tgt_out_valid | output | 1 | Debugger-to-target word pending (R flag) |
| tgt_out_ready | input | 1 | Target takes the pending word |
| tgt_out_data | output | DATA_W | Pending debugger-to-target word |

## Verification
The bench builds the block with its default 32-bit data, 5-bit address and control and data addresses 4 and 5. It overrides VERSION with 4'hA so the version nibble cannot be mistaken for a flag or a zero default. A sweep covers every combination of debugger write, debugger read, address choice (control, data, unused), target push and target take, several times over. A control read follows each step. This puts every collision within reach: a push during a destructive read, a write during a drain, an overrun during a clear, and reads of unused addresses, all from both empty and full mailbox states. A directed burst of unpolled writes against a target that takes a word every cycle exercises streaming delivery.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int unsigned FLAG_R_BIT   = 0;
  localparam int unsigned FLAG_W_BIT   = 1;
  localparam int unsigned FLAG_OVR_BIT = 2;
  localparam int unsigned VER_W        = 4;

  typedef struct packed {
    logic ovr;
    logic w_full;
    logic r_full;
  } dcc_flags_t;
endpackage

// File: rtl/dcc_slot.sv
module dcc_slot #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              put,
  input  logic [DATA_W-1:0] put_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              ovr_evt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= put | (full & ~take);
      if (put) data <= put_data;
    end
  end

  assign ovr_evt = put & full & ~take;
endmodule

// File: rtl/dcc_overrun.sv
module dcc_overrun (
  input  logic clk,
  input  logic rst_n,
  input  logic set_a,
  input  logic set_b,
  input  logic clr,
  output logic ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ovr <= 1'b0;
    else if (set_a | set_b) ovr <= 1'b1;
    else if (clr)           ovr <= 1'b0;
  end
endmodule

// File: rtl/dcc_readmux.sv
module dcc_readmux #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              sel_ctrl,
  input  logic              sel_data,
  input  logic [DATA_W-1:0] ctrl_word,
  input  logic [DATA_W-1:0] data_word,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] next_word;

  always_comb begin
    next_word = '0;
    if (sel_ctrl)      next_word = ctrl_word;
    else if (sel_data) next_word = data_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= next_word;
  end
endmodule

// File: rtl/dcc_mailbox.sv
module dcc_mailbox
  import dcc_pkg::*;
#(
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       ADDR_W    = 5,
  parameter int unsigned       CTRL_ADDR = 4,
  parameter int unsigned       DATA_ADDR = 5,
  parameter logic [VER_W-1:0]  VERSION   = 4'h6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic              dbg_wr_en,
  input  logic              dbg_rd_en,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  input  logic              tgt_in_valid,
  output logic              tgt_in_ready,
  input  logic [DATA_W-1:0] tgt_in_data,
  output logic              tgt_out_valid,
  input  logic              tgt_out_ready,
  output logic [DATA_W-1:0] tgt_out_data
);
  localparam int unsigned PAD_W = DATA_W - VER_W - 3;

  logic              hit_ctrl, hit_data;
  logic              dbg_data_wr, dbg_data_rd, dbg_ctrl_wr;
  logic              w_full, r_full, ovr;
  logic              ovr_in, ovr_out;
  logic              out_take;
  logic [DATA_W-1:0] in_word;
  logic [DATA_W-1:0] ctrl_word;
  dcc_flags_t        flags;

  assign hit_ctrl    = (dbg_addr == ADDR_W'(CTRL_ADDR));
  assign hit_data    = (dbg_addr == ADDR_W'(DATA_ADDR));
  assign dbg_data_wr = dbg_wr_en & hit_data;
  assign dbg_data_rd = dbg_rd_en & hit_data;
  assign dbg_ctrl_wr = dbg_wr_en & hit_ctrl;
  assign out_take    = tgt_out_ready & r_full;

  // target -> debugger
  dcc_slot #(.DATA_W(DATA_W)) u_in_slot (
    .clk(clk), .rst_n(rst_n),
    .put(tgt_in_valid), .put_data(tgt_in_data), .take(dbg_data_rd),
    .full(w_full), .data(in_word), .ovr_evt(ovr_in)
  );

  // debugger -> target
  dcc_slot #(.DATA_W(DATA_W)) u_out_slot (
    .clk(clk), .rst_n(rst_n),
    .put(dbg_data_wr), .put_data(dbg_wdata), .take(out_take),
    .full(r_full), .data(tgt_out_data), .ovr_evt(ovr_out)
  );

  dcc_overrun u_ovr (
    .clk(clk), .rst_n(rst_n),
    .set_a(ovr_in), .set_b(ovr_out),
    .clr(dbg_ctrl_wr & dbg_wdata[FLAG_OVR_BIT]),
    .ovr(ovr)
  );

  assign flags     = '{ovr: ovr, w_full: w_full, r_full: r_full};
  assign ctrl_word = {VERSION, {PAD_W{1'b0}}, flags};

  dcc_readmux #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(dbg_rd_en),
    .sel_ctrl(hit_ctrl), .sel_data(hit_data),
    .ctrl_word(ctrl_word), .data_word(in_word), .rdata(dbg_rdata)
  );

  assign tgt_in_ready  = 1'b1;
  assign tgt_out_valid = r_full;
endmodule

// File: rtl/dcc_mailbox_chk.sv
module dcc_mailbox_chk #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned CTRL_ADDR = 4,
  parameter int unsigned DATA_ADDR = 5,
  parameter logic [3:0]  VERSION   = 4'h6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] dbg_addr,
  input logic              dbg_wr_en,
  input logic              dbg_rd_en,
  input logic [DATA_W-1:0] dbg_wdata,
  input logic [DATA_W-1:0] dbg_rdata,
  input logic              tgt_in_valid,
  input logic              tgt_out_valid,
  input logic              tgt_out_ready,
  input logic [DATA_W-1:0] tgt_out_data,
  input logic              w_full,
  input logic              ovr
);
  logic at_ctrl, at_data;
  assign at_ctrl = (dbg_addr == ADDR_W'(CTRL_ADDR));
  assign at_data = (dbg_addr == ADDR_W'(DATA_ADDR));

  // R2
  version_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_rd_en && at_ctrl) |=> (dbg_rdata[DATA_W-1 -: 4] == VERSION) && (dbg_rdata[DATA_W-5:3] == '0));

  // R3
  ctrl_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_rd_en && at_ctrl && !dbg_wr_en && !tgt_in_valid && !tgt_out_ready)
      |=> $stable(w_full) && $stable(tgt_out_valid) && $stable(ovr) && $stable(tgt_out_data));

  // R4
  w_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_in_valid |=> w_full);

  // R5
  w_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_rd_en && at_data && !tgt_in_valid) |=> !w_full);

  // R6
  r_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_wr_en && at_data) |=> tgt_out_valid && (tgt_out_data == $past(dbg_wdata)));

  // R7
  r_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_out_valid && tgt_out_ready && !(dbg_wr_en && at_data)) |=> !tgt_out_valid);

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !(dbg_wr_en && at_ctrl && dbg_wdata[2])) |=> ovr);

  // R8
  ovr_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_out_valid && !tgt_out_ready && dbg_wr_en && at_data) |=> ovr);
endmodule

bind dcc_mailbox dcc_mailbox_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
  .DATA_ADDR(DATA_ADDR), .VERSION(VERSION)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_addr(dbg_addr), .dbg_wr_en(dbg_wr_en),
  .dbg_rd_en(dbg_rd_en), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
  .tgt_in_valid(tgt_in_valid), .tgt_out_valid(tgt_out_valid),
  .tgt_out_ready(tgt_out_ready), .tgt_out_data(tgt_out_data),
  .w_full(w_full), .ovr(ovr)
);

// File: tb/test_dcc_mailbox.sv
module test_dcc_mailbox;
  localparam logic [3:0] VER = 4'hA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  dbg_addr = '0;
  logic        dbg_wr_en = 1'b0, dbg_rd_en = 1'b0;
  logic [31:0] dbg_wdata = '0, dbg_rdata;
  logic        tgt_in_valid = 1'b0, tgt_in_ready;
  logic [31:0] tgt_in_data = '0;
  logic        tgt_out_valid, tgt_out_ready = 1'b0;
  logic [31:0] tgt_out_data;

  int checks = 0, failures = 0;

  // bench model
  bit          m_r, m_w, m_ovr;
  logic [31:0] m_in, m_out, m_rd;

  always #10 clk = ~clk;

  dcc_mailbox #(.VERSION(VER)) i_dcc_mailbox (
    .clk(clk), .rst_n(rst_n), .dbg_addr(dbg_addr), .dbg_wr_en(dbg_wr_en),
    .dbg_rd_en(dbg_rd_en), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .tgt_in_valid(tgt_in_valid), .tgt_in_ready(tgt_in_ready),
    .tgt_in_data(tgt_in_data), .tgt_out_valid(tgt_out_valid),
    .tgt_out_ready(tgt_out_ready), .tgt_out_data(tgt_out_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_val();
    return {VER, 25'b0, m_ovr, m_w, m_r};
  endfunction

  task automatic step(input bit wr, input bit rd, input logic [4:0] a, input logic [31:0] wd,
                      input bit tv, input logic [31:0] td, input bit tr, input string tag);
    bit dw, dr, cw, tp, evt;
    string t;
    @(negedge clk);
    dbg_wr_en = wr; dbg_rd_en = rd; dbg_addr = a; dbg_wdata = wd;
    tgt_in_valid = tv; tgt_in_data = td; tgt_out_ready = tr;
    dw = wr && a == 5; dr = rd && a == 5; cw = wr && a == 4;
    tp = tr && m_r;
    if (rd) m_rd = (a == 4) ? ctrl_val() : (a == 5) ? m_in : 32'h0;
    evt = (dw && m_r && !tp) || (tv && m_w && !dr);
    if (tv) m_in = td;
    m_w = tv || (m_w && !dr);
    if (dw) m_out = wd;
    m_r = dw || (m_r && !tp);
    if (evt) m_ovr = 1'b1;
    else if (cw && wd[2]) m_ovr = 1'b0;
    @(posedge clk);
    #1;
    if (tag != "") t = tag;
    else if (rd && a == 4) t = (wr || tv || tr) ? "R2" : "R2/R3";
    else if (rd && a == 5) t = tv ? "R5/R8" : "R5";
    else if (rd) t = "R10";
    else t = "R2";
    chk(dbg_rdata === m_rd, t, dbg_rdata, m_rd);
    chk(tgt_out_valid === m_r, tp ? "R7" : "R6", {31'b0, tgt_out_valid}, {31'b0, m_r});
    if (m_r) chk(tgt_out_data === m_out, (tag != "") ? tag : "R6", tgt_out_data, m_out);
    chk(tgt_in_ready === 1'b1, "R4", {31'b0, tgt_in_ready}, 32'h1);
    dbg_wr_en = 0; dbg_rd_en = 0; tgt_in_valid = 0; tgt_out_ready = 0;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_r = 0; m_w = 0; m_ovr = 0; m_in = 0; m_out = 0; m_rd = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(dbg_rdata === 32'h0, "R1", dbg_rdata, 32'h0);
    chk(tgt_out_valid === 1'b0, "R1", {31'b0, tgt_out_valid}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    step(0, 1, 5'd4, 0, 0, 0, 0, "R1");

    // near-exhaustive sweep over strobe combinations
    for (int pass = 0; pass < 4; pass++) begin
      for (int c = 0; c < 64; c++) begin
        logic [4:0]  a;
        logic [31:0] wd, td;
        case (c[3:2])
          2'd0: a = 5'd4;
          2'd1: a = 5'd5;
          2'd2: a = 5'd7 + 5'(pass);
          default: a = 5'd5;
        endcase
        wd = 32'hA500_0000 + 32'(c * 7 + pass * 131);
        td = 32'h3C00_0000 + 32'(c * 13 + pass * 17);
        step(c[0], c[1], a, wd, c[4], td, c[5], "");
        // flags readback: R4 W, R8 overrun, R9 clear
        step(0, 1, 5'd4, 0, 0, 0, 0, (c[0] && a == 4) ? "R9" : (c[4] ? "R4/R8" : "R8"));
      end
    end

    // R9 clear with bit2 set, other bits ignored
    step(1, 0, 5'd5, 32'h1, 0, 0, 0, "R9");
    step(1, 0, 5'd5, 32'h2, 0, 0, 0, "R8");
    step(1, 0, 5'd4, 32'hFFFF_FFFF, 0, 0, 0, "R9");
    step(0, 1, 5'd4, 0, 0, 0, 0, "R9");
    // R9 overrun in same cycle as clear: set wins
    step(1, 0, 5'd4, 32'h4, 1, 32'h77, 0, "R9");
    step(1, 0, 5'd4, 32'h4, 1, 32'h78, 0, "R9");
    step(0, 1, 5'd4, 0, 0, 0, 0, "R9");
    step(0, 1, 5'd5, 0, 0, 0, 0, "R5");
    step(1, 0, 5'd4, 32'h4, 0, 0, 1, "R9");
    step(0, 1, 5'd4, 0, 0, 0, 0, "R9");

    // R11 unpolled burst with target draining every cycle
    for (int k = 0; k < 6; k++)
      step(1, 0, 5'd5, 32'hBEEF_0000 + 32'(k), 0, 0, 1, "R11");
    step(0, 0, 5'd0, 0, 0, 0, 1, "R11");
    step(0, 1, 5'd4, 0, 0, 0, 0, "R11");
    chk(dbg_rdata[2] === 1'b0, "R11", dbg_rdata, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule